// File: doc/BRIEF.md
# Raster Sync and Frame Interrupt Generator

This block keeps the horizontal and vertical position of a fixed raster display. It advances one position for each cycle in which the pixel enable is high. From that position it makes an active-low line sync, an active-low frame sync, a flag that marks the visible pixel window, and a level frame interrupt request. The current column and line are brought out so that neighbouring blocks can time memory fetches and pixel output against them.

Every output is a register, and it is loaded on the same enabled edge as the counters. Each output therefore matches the `x_o`/`y_o` value shown in the same cycle. The frame sync does not end on a line boundary: it is released halfway through the third line. The interrupt request rises on the first line after the visible window. It stays high until the next frame begins, and it has no acknowledge input. The default geometry is 1024 positions per line and 312 lines per frame. Every boundary is a parameter.

Top module: `raster_timing`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first enabled edge, `x_o` and `y_o` are 0, `hsync_no` and `vsync_no` are 1, and `active_o` and `frame_irq_o` are 0.
- R2: On an edge with `pix_en_i` high, `x_o` increases by one. On an edge with `pix_en_i` low, `x_o`, `y_o` and all four flags keep their values.
- R3: When an enabled edge finds `x_o` at LINE_LEN-1 (1023), `x_o` becomes 0 and `y_o` increases by one. When `y_o` is also at FRAME_LINES-1 (311), `y_o` becomes 0. `x_o` never reaches LINE_LEN and `y_o` never reaches FRAME_LINES.
- R4: After the first enabled edge, `hsync_no` is 0 exactly while `x_o` < HS_END (64), and 1 otherwise.
- R5: After the first enabled edge, `vsync_no` is 0 exactly while `y_o` is below VS_END_LINE (2), or while `y_o` equals VS_END_LINE and `x_o` < VS_END_POS (512). It is 1 otherwise.
- R6: `active_o` is 1 exactly while `y_o` is in ACT_Y0..ACT_Y0+ACT_H-1 (28..283) and `x_o` is in ACT_X0..ACT_X0+ACT_W-1 (256..895).
- R7: `frame_irq_o` goes to 1 when the position reaches column 0 of line ACT_Y0+ACT_H (284). It goes back to 0 when the position reaches column 0 of line 0. It is therefore 1 exactly while `y_o` >= ACT_Y0+ACT_H.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | Advance one position on this edge |
| x_o | output | XW (10) | Current column |
| y_o | output | YW (9) | Current line |
| hsync_no | output | 1 | Line sync, active low |
| vsync_no | output | 1 | Frame sync, active low |
| active_o | output | 1 | Inside the visible pixel window |
| frame_irq_o | output | 1 | Frame interrupt request, level |

## Verification
The bench runs several complete frames with a scaled geometry and an irregular enable pattern, including long gaps, and compares every output on every cycle. It targets the following faults:
- An off-by-one on any window edge. This would move a sync or window transition by a single position.
- Ending frame sync at the start of its line instead of its middle. This would release `vsync_no` half a line early.
- An interrupt that is not held across the frame wrap, or is cleared one line late. Either would make `frame_irq_o` disagree with the line number.
- A flag that is updated on non-enabled cycles. This would make it drift ahead of the counters.

A reset applied in the middle of a frame checks that the first frame after reset starts clean.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // inclusive range test on unsigned positions
  function automatic logic in_span(input int unsigned v, input int unsigned lo,
                                   input int unsigned hi);
    return (v >= lo) && (v <= hi);
  endfunction

endpackage

// File: rtl/raster_counter.sv
module raster_counter #(
  parameter int LINE_LEN    = 1024,
  parameter int FRAME_LINES = 312,
  parameter int XW          = 10,
  parameter int YW          = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic [XW-1:0] x_q_o,
  output logic [YW-1:0] y_q_o,
  output logic [XW-1:0] x_nxt_o,
  output logic [YW-1:0] y_nxt_o
);
  localparam logic [XW-1:0] X_LAST = XW'(LINE_LEN - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(FRAME_LINES - 1);

  logic [XW-1:0] x_q;
  logic [YW-1:0] y_q;

  always_comb begin
    x_nxt_o = x_q + XW'(1);
    y_nxt_o = y_q;
    if (x_q == X_LAST) begin
      x_nxt_o = '0;
      y_nxt_o = (y_q == Y_LAST) ? '0 : y_q + YW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      y_q <= '0;
    end else if (en_i) begin
      x_q <= x_nxt_o;
      y_q <= y_nxt_o;
    end
  end

  assign x_q_o = x_q;
  assign y_q_o = y_q;
endmodule

// File: rtl/raster_decode.sv
module raster_decode
  import raster_pkg::*;
#(
  parameter int XW          = 10,
  parameter int YW          = 9,
  parameter int HS_END      = 64,
  parameter int VS_END_LINE = 2,
  parameter int VS_END_POS  = 512,
  parameter int ACT_X0      = 256,
  parameter int ACT_W       = 640,
  parameter int ACT_Y0      = 28,
  parameter int ACT_H       = 256
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [XW-1:0] x_nxt_i,
  input  logic [YW-1:0] y_nxt_i,
  output logic          hsync_no,
  output logic          vsync_no,
  output logic          active_o
);
  localparam logic [XW-1:0] HS_X  = XW'(HS_END);
  localparam logic [XW-1:0] VS_X  = XW'(VS_END_POS);
  localparam logic [YW-1:0] VS_Y  = YW'(VS_END_LINE);
  localparam int unsigned   AX_LO = ACT_X0;
  localparam int unsigned   AX_HI = ACT_X0 + ACT_W - 1;
  localparam int unsigned   AY_LO = ACT_Y0;
  localparam int unsigned   AY_HI = ACT_Y0 + ACT_H - 1;

  logic hs_low, vs_low, in_win;

  // decoded from the position being entered, so flags line up with x/y
  always_comb begin
    hs_low = x_nxt_i < HS_X;
    vs_low = (y_nxt_i < VS_Y) || ((y_nxt_i == VS_Y) && (x_nxt_i < VS_X));
    in_win = in_span(32'(y_nxt_i), AY_LO, AY_HI) &&
             in_span(32'(x_nxt_i), AX_LO, AX_HI);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsync_no <= 1'b1;
      vsync_no <= 1'b1;
      active_o <= 1'b0;
    end else if (en_i) begin
      hsync_no <= ~hs_low;
      vsync_no <= ~vs_low;
      active_o <= in_win;
    end
  end
endmodule

// File: rtl/raster_irq.sv
module raster_irq #(
  parameter int XW       = 10,
  parameter int YW       = 9,
  parameter int IRQ_LINE = 284
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [XW-1:0] x_nxt_i,
  input  logic [YW-1:0] y_nxt_i,
  output logic          irq_o
);
  localparam logic [YW-1:0] IRQ_Y = YW'(IRQ_LINE);

  logic at_col0, set_ev, clr_ev;

  assign at_col0 = (x_nxt_i == '0);
  assign set_ev  = en_i && at_col0 && (y_nxt_i == IRQ_Y);
  assign clr_ev  = en_i && at_col0 && (y_nxt_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     irq_o <= 1'b0;
    else if (clr_ev) irq_o <= 1'b0;
    else if (set_ev) irq_o <= 1'b1;
  end
endmodule

// File: rtl/raster_timing.sv
module raster_timing #(
  parameter int LINE_LEN    = 1024,
  parameter int FRAME_LINES = 312,
  parameter int HS_END      = 64,
  parameter int VS_END_LINE = 2,
  parameter int VS_END_POS  = 512,
  parameter int ACT_X0      = 256,
  parameter int ACT_W       = 640,
  parameter int ACT_Y0      = 28,
  parameter int ACT_H       = 256,
  localparam int XW         = $clog2(LINE_LEN),
  localparam int YW         = $clog2(FRAME_LINES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pix_en_i,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o,
  output logic          hsync_no,
  output logic          vsync_no,
  output logic          active_o,
  output logic          frame_irq_o
);
  localparam int IRQ_LINE = ACT_Y0 + ACT_H;

  logic [XW-1:0] x_nxt;
  logic [YW-1:0] y_nxt;

  raster_counter #(
    .LINE_LEN(LINE_LEN), .FRAME_LINES(FRAME_LINES), .XW(XW), .YW(YW)
  ) i_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(pix_en_i),
    .x_q_o(x_o), .y_q_o(y_o), .x_nxt_o(x_nxt), .y_nxt_o(y_nxt)
  );

  raster_decode #(
    .XW(XW), .YW(YW), .HS_END(HS_END), .VS_END_LINE(VS_END_LINE),
    .VS_END_POS(VS_END_POS), .ACT_X0(ACT_X0), .ACT_W(ACT_W),
    .ACT_Y0(ACT_Y0), .ACT_H(ACT_H)
  ) i_decode (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(pix_en_i),
    .x_nxt_i(x_nxt), .y_nxt_i(y_nxt),
    .hsync_no(hsync_no), .vsync_no(vsync_no), .active_o(active_o)
  );

  raster_irq #(
    .XW(XW), .YW(YW), .IRQ_LINE(IRQ_LINE)
  ) i_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(pix_en_i),
    .x_nxt_i(x_nxt), .y_nxt_i(y_nxt), .irq_o(frame_irq_o)
  );
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
  parameter int LINE_LEN    = 1024,
  parameter int FRAME_LINES = 312,
  parameter int HS_END      = 64,
  parameter int VS_END_LINE = 2,
  parameter int VS_END_POS  = 512,
  parameter int ACT_X0      = 256,
  parameter int ACT_W       = 640,
  parameter int ACT_Y0      = 28,
  parameter int ACT_H       = 256,
  parameter int XW          = 10,
  parameter int YW          = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pix_en_i,
  input logic [XW-1:0] x_o,
  input logic [YW-1:0] y_o,
  input logic          hsync_no,
  input logic          vsync_no,
  input logic          active_o,
  input logic          frame_irq_o
);
  localparam logic [XW-1:0] X_LAST = XW'(LINE_LEN - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(FRAME_LINES - 1);
  localparam int IRQ_LINE = ACT_Y0 + ACT_H;

  assert_x_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(x_o) < LINE_LEN);
  assert_y_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(y_o) < FRAME_LINES);
  assert_x_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_en_i && x_o != X_LAST) |=> (x_o == $past(x_o) + XW'(1)) && $stable(y_o));
  assert_line_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_en_i && x_o == X_LAST && y_o != Y_LAST) |=> (x_o == '0) && (y_o == $past(y_o) + YW'(1)));
  assert_frame_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_en_i && x_o == X_LAST && y_o == Y_LAST) |=> (x_o == '0) && (y_o == '0));
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_en_i |=> $stable(x_o) && $stable(y_o) && $stable(hsync_no) &&
                  $stable(vsync_no) && $stable(active_o) && $stable(frame_irq_o));
  assert_hsync_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsync_no |-> 32'(x_o) < HS_END);
  assert_vsync_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_no |-> 32'(y_o) <= VS_END_LINE);
  assert_active_window_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (32'(x_o) >= ACT_X0) && (32'(x_o) < ACT_X0 + ACT_W) &&
                 (32'(y_o) >= ACT_Y0) && (32'(y_o) < ACT_Y0 + ACT_H));
  assert_irq_region_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_irq_o == (32'(y_o) >= IRQ_LINE));
  initial assert_vs_pos_fits_R5: assert (VS_END_POS < LINE_LEN);
endmodule

bind raster_timing raster_timing_chk #(
  .LINE_LEN(LINE_LEN), .FRAME_LINES(FRAME_LINES), .HS_END(HS_END),
  .VS_END_LINE(VS_END_LINE), .VS_END_POS(VS_END_POS), .ACT_X0(ACT_X0),
  .ACT_W(ACT_W), .ACT_Y0(ACT_Y0), .ACT_H(ACT_H), .XW(XW), .YW(YW)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pix_en_i(pix_en_i), .x_o(x_o), .y_o(y_o),
  .hsync_no(hsync_no), .vsync_no(vsync_no), .active_o(active_o),
  .frame_irq_o(frame_irq_o)
);

// File: tb/test_raster_timing.sv
module test_raster_timing;
  // scaled geometry so that several frames fit the run
  localparam int LL  = 64;
  localparam int FL  = 20;
  localparam int HSE = 8;
  localparam int VSL = 2;
  localparam int VSP = 32;
  localparam int AX0 = 16;
  localparam int AW  = 40;
  localparam int AY0 = 5;
  localparam int AH  = 12;
  localparam int XW  = $clog2(LL);
  localparam int YW  = $clog2(FL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [XW-1:0] x;
  logic [YW-1:0] y;
  logic hs_n, vs_n, act, irq;

  int total = 0;
  int bad = 0;
  int mx = 0, my = 0;
  bit started = 0;
  bit done = 0;

  always #5 clk = ~clk;

  raster_timing #(
    .LINE_LEN(LL), .FRAME_LINES(FL), .HS_END(HSE), .VS_END_LINE(VSL),
    .VS_END_POS(VSP), .ACT_X0(AX0), .ACT_W(AW), .ACT_Y0(AY0), .ACT_H(AH)
  ) i_raster_timing (
    .clk_i(clk), .rst_ni(rst_n), .pix_en_i(en), .x_o(x), .y_o(y),
    .hsync_no(hs_n), .vsync_no(vs_n), .active_o(act), .frame_irq_o(irq)
  );

  task automatic check(input string req, input int act_v, input int exp_v);
    total++;
    if (act_v != exp_v) begin
      bad++;
      $display("FAIL %s at x=%0d y=%0d: actual=%0d expected=%0d", req, mx, my, act_v, exp_v);
    end
  endtask

  task automatic model_step();
    started = 1;
    mx++;
    if (mx == LL) begin
      mx = 0;
      my = (my == FL - 1) ? 0 : my + 1;
    end
  endtask

  task automatic compare_all();
    int e_hs, e_vs, e_act, e_irq;
    e_hs  = started ? int'(mx >= HSE) : 1;
    e_vs  = started ? int'(!((my < VSL) || (my == VSL && mx < VSP))) : 1;
    e_act = int'(my >= AY0 && my < AY0 + AH && mx >= AX0 && mx < AX0 + AW);
    e_irq = int'(my >= AY0 + AH);
    check("R2/R3 x", int'(x), mx);
    check("R3 y", int'(y), my);
    check("R4 hsync", int'(hs_n), e_hs);
    check("R5 vsync", int'(vs_n), e_vs);
    check("R6 active", int'(act), e_act);
    check("R7 irq", int'(irq), e_irq);
  endtask

  // one cycle: model follows the enable seen at the last edge, then new enable
  task automatic cycle(input bit next_en);
    @(negedge clk);
    if (en) model_step();
    compare_all();
    en = next_en;
  endtask

  task automatic check_reset_state();
    check("R1 x", int'(x), 0);
    check("R1 y", int'(y), 0);
    check("R1 hsync", int'(hs_n), 1);
    check("R1 vsync", int'(vs_n), 1);
    check("R1 active", int'(act), 0);
    check("R1 irq", int'(irq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    // R1: stays in reset state until first enable
    for (int i = 0; i < 4; i++) cycle(1'b0);
    check_reset_state();
    // R2 R3: steady enable through more than one frame
    for (int i = 0; i < LL * FL + 200; i++) cycle(1'b1);
    // R2: long gap with enable low
    for (int i = 0; i < 50; i++) cycle(1'b0);
    // irregular enable over about two frames
    for (int i = 0; i < 3600; i++) cycle($urandom_range(0, 3) != 0);
    // reset in the middle of a frame
    @(negedge clk);
    en = 1'b0;
    rst_n = 1'b0;
    mx = 0; my = 0; started = 0;
    @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    // R1 R7: clean restart, then through the interrupt line
    for (int i = 0; i < LL * (AY0 + AH + 2); i++) cycle(1'b1);
    @(negedge clk);
    if (en) model_step();
    compare_all();
    en = 1'b0;
    done = 1;
  end

  initial begin
    int n = 0;
    while (!done && n < 100000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=done", n);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule